// File: doc/BRIEF.md
# Two-Level DMA Channel Scheduler

This block decides, every clock cycle, which DMA channel may issue the next bus transfer. Each channel drives three lines: a request-ready line, an enable bit and a high-priority flag. A channel is eligible when it is both ready and enabled. The scheduler returns a registered one-hot grant, or an all-zero grant when no channel is eligible.

Scheduling runs in rounds. In a round, each eligible high-priority channel that has not yet been served in that round is granted once. Then a single low-priority channel gets one slot, and a new round begins. Within each class, a round-robin pointer moves one place past the channel last granted from that class.

The priority flag only changes the order of grants. When demand is light, a low-priority channel loses no slots. Clearing a channel's enable bit stops its grants without moving either pointer, so its sequence pauses and later resumes where it stopped.

Top module: `dsch_sched`

## Requirements
- R1: `grant_o` is a register. It is zero while reset is held and after reset. At every cycle it has at most one bit set, and bit i means channel i is granted.
- R2: Channel i can be granted in cycle t+1 only if `req_i[i]` and `en_i[i]` were both 1 at the clock edge that ends cycle t. A ready channel with its enable bit at 0 is never granted.
- R3: If any channel was eligible at a clock edge, the grant after that edge is non-zero. The scheduler never leaves a slot idle.
- R4: While an eligible high-priority channel has not yet been granted in the current round, the next grant goes to a high-priority channel.
- R5: A round contains at most one low-priority grant. After a low-priority grant, the next grant goes to a high-priority channel whenever one is eligible.
- R6: If no high-priority channel is eligible, an eligible low-priority channel is granted at the next edge, without waiting.
- R7: If every eligible high-priority channel has been served in the round and no low-priority channel is eligible, the low slot is skipped. A new round starts, and a high-priority channel is granted at that same edge.
- R8: Within each class, the grant goes to the first eligible channel at or after that class's pointer, counting upward with wrap-around. The pointer then moves to one past the granted channel.
- R9: Disabling a channel does not move either pointer. When the channel is re-enabled, it is served at its place in the round-robin order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_CH | Request-ready line per channel |
| en_i | input | N_CH | Enable bit per channel |
| hi_i | input | N_CH | High-priority flag per channel |
| grant_o | output | N_CH | Registered one-hot grant, or zero |

## Verification
The bench targets the edges of a round:
- **End of the high-priority sweep.** A design that skipped the low slot would starve low-priority channels. One that allowed two low grants per round would delay high-priority channels.
- **Low slot with no low-priority channel ready.** A design that idled here would leave a bubble while work is pending.
- **Pointer wrap at the top channel index.** An off-by-one pointer would grant the same channel twice or skip a channel.
- **Enable toggled mid-stream.** The bench disables a channel in the middle of a stream and re-enables it later. A design that reset or moved a pointer on disable would put the channel back out of order.

Every combination of ready, enable and priority for a four-channel configuration is applied over several consecutive cycles. Each grant is compared against an arithmetic model of the round.

// File: rtl/dsch_pkg.sv
// Package: shared types for the two-level channel scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package dsch_pkg;
    // Class of the slot granted in a cycle.
    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_HI     = 2'd1,
        SLOT_LO     = 2'd2,
        SLOT_HI_NEW = 2'd3
    } slot_e;
endpackage

// File: rtl/dsch_rr_pick.sv
// Module: dsch_rr_pick
// Combinational round-robin picker. It finds the first set bit of cand,
// starting at index ptr and counting upward with wrap-around.
// Assumes: ptr < N.
module dsch_rr_pick #(
    parameter int N  = 12,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  pick,
    output logic [IW-1:0] pick_idx,
    output logic          found
);
    // Scan each offset from the pointer and keep the first hit.
    always_comb begin
        pick     = '0;
        pick_idx = '0;
        found    = 1'b0;
        for (int o = 0; o < N; o++) begin
            int s;
            s = int'(ptr) + o;
            if (s >= N) s = s - N;
            if (!found && cand[s]) begin
                found    = 1'b1;
                pick_idx = IW'(s);
                pick[s]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsch_ptr.sv
// Module: dsch_ptr
// Round-robin pointer register. When adv is 1, it loads one past idx,
// wrapping to zero after N-1.
// Assumes: idx < N whenever adv is 1.
module dsch_ptr #(
    parameter int N  = 12,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [IW-1:0] idx,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    // Move past the granted channel; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= (idx == LAST) ? '0 : idx + IW'(1);
    end
endmodule

// File: rtl/dsch_sched.sv
// Module: dsch_sched
// Two-level DMA channel scheduler. Eligible high-priority channels are
// served once each per round. One low-priority slot then closes the round.
// Each class has its own round-robin pointer. The grant is registered.
// Assumes: req_i, en_i and hi_i are synchronous to clk.
module dsch_sched #(
    parameter int N_CH = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] req_i,
    input  logic [N_CH-1:0] en_i,
    input  logic [N_CH-1:0] hi_i,
    output logic [N_CH-1:0] grant_o
);
    import dsch_pkg::*;

    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [N_CH-1:0] elig, hi_elig, lo_elig, hi_cand;
    logic [N_CH-1:0] served_q, served_d, grant_d;
    logic [N_CH-1:0] hp_pick, ha_pick, lo_pick;
    logic [IW-1:0]   hp_idx, ha_idx, lo_idx;
    logic            hp_found, ha_found, lo_found;
    logic [IW-1:0]   hptr, lptr, hidx;
    logic            hadv, ladv;
    slot_e           slot_d, slot_q;

    assign elig    = req_i & en_i;
    assign hi_elig = elig & hi_i;
    assign lo_elig = elig & ~hi_i;
    assign hi_cand = hi_elig & ~served_q;

    // High-priority channels not yet served in this round.
    dsch_rr_pick #(.N(N_CH), .IW(IW)) u_hi_pend (
        .cand(hi_cand), .ptr(hptr),
        .pick(hp_pick), .pick_idx(hp_idx), .found(hp_found)
    );

    // All eligible high-priority channels, used when a new round starts.
    dsch_rr_pick #(.N(N_CH), .IW(IW)) u_hi_all (
        .cand(hi_elig), .ptr(hptr),
        .pick(ha_pick), .pick_idx(ha_idx), .found(ha_found)
    );

    // Low-priority slot.
    dsch_rr_pick #(.N(N_CH), .IW(IW)) u_lo (
        .cand(lo_elig), .ptr(lptr),
        .pick(lo_pick), .pick_idx(lo_idx), .found(lo_found)
    );

    // Choose the slot for this cycle and update the round state.
    always_comb begin
        grant_d  = '0;
        served_d = served_q;
        hadv     = 1'b0;
        ladv     = 1'b0;
        hidx     = hp_idx;
        slot_d   = SLOT_NONE;
        if (hp_found) begin
            grant_d  = hp_pick;
            served_d = served_q | hp_pick;
            hadv     = 1'b1;
            slot_d   = SLOT_HI;
        end else if (lo_found) begin
            grant_d  = lo_pick;
            served_d = '0;
            ladv     = 1'b1;
            slot_d   = SLOT_LO;
        end else if (ha_found) begin
            grant_d  = ha_pick;
            served_d = ha_pick;
            hadv     = 1'b1;
            hidx     = ha_idx;
            slot_d   = SLOT_HI_NEW;
        end else begin
            served_d = '0;
        end
    end

    dsch_ptr #(.N(N_CH), .IW(IW)) u_hptr (
        .clk(clk), .rst_n(rst_n), .adv(hadv), .idx(hidx), .ptr(hptr)
    );

    dsch_ptr #(.N(N_CH), .IW(IW)) u_lptr (
        .clk(clk), .rst_n(rst_n), .adv(ladv), .idx(lo_idx), .ptr(lptr)
    );

    // Register the grant, the served set and the class of the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o  <= '0;
            served_q <= '0;
            slot_q   <= SLOT_NONE;
        end else begin
            grant_o  <= grant_d;
            served_q <= served_d;
            slot_q   <= slot_d;
        end
    end

    // R1: at most one channel granted.
    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2: a grant goes only to a channel that was ready and enabled.
    assert_eligible_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((grant_o & ~$past(req_i & en_i)) == '0));

    // R3: no idle slot while any channel is eligible.
    assert_no_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_i & en_i)) |=> (|grant_o));

    // R5: after a low slot, a pending high-priority channel goes next.
    assert_one_lo_per_round_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q == SLOT_LO) && (|(req_i & en_i & hi_i)))
        |=> (|(grant_o & $past(hi_i))));

    // R6: with no high-priority demand, a low-priority channel is taken at once.
    assert_lo_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(req_i & en_i & hi_i)) && (|(req_i & en_i & ~hi_i)))
        |=> (|(grant_o & ~$past(hi_i))));
endmodule

// File: tb/tb_dsch_sched.sv
`timescale 1ns/1ps
// Bench for dsch_sched with four channels. Directed scenarios come first.
// A sweep then applies every ready/enable/priority combination for three
// cycles each. Every grant is compared with an arithmetic model of the round.
module tb_dsch_sched;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0, en = '0, hi = '0;
    logic [N-1:0] grant;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    logic [N-1:0] m_served, m_exp;
    int           m_hptr, m_lptr;

    always #2 clk = ~clk;

    dsch_sched #(.N_CH(N)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .hi_i(hi),
        .grant_o(grant)
    );

    // First set bit of c at or after p, with wrap; -1 if c is empty.
    function automatic int rr(input logic [N-1:0] c, input int p);
        for (int o = 0; o < N; o++) begin
            if (c[(p + o) % N]) return (p + o) % N;
        end
        return -1;
    endfunction

    // Advance the model by one clock edge, using the current inputs.
    task automatic model_step();
        logic [N-1:0] el, he, le, hc;
        int k;
        el = req & en; he = el & hi; le = el & ~hi; hc = he & ~m_served;
        m_exp = '0;
        if (hc != '0) begin
            k = rr(hc, m_hptr); m_exp[k] = 1'b1;
            m_served = m_served | m_exp; m_hptr = (k + 1) % N;
        end else if (le != '0) begin
            k = rr(le, m_lptr); m_exp[k] = 1'b1;
            m_served = '0; m_lptr = (k + 1) % N;
        end else if (he != '0) begin
            k = rr(he, m_hptr); m_exp[k] = 1'b1;
            m_served = m_exp; m_hptr = (k + 1) % N;
        end else begin
            m_served = '0;
        end
    endtask

    // Apply one edge, then compare the grant away from that edge.
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        n_vec++;
        if (grant !== m_exp) begin
            n_miss++;
            $display("FAIL %s: grant=%b expected=%b (req=%b en=%b hi=%b)",
                     tag, grant, m_exp, req, en, hi);
        end
    endtask

    // Drive new inputs (called at the falling edge).
    task automatic drive(input logic [N-1:0] r, input logic [N-1:0] e,
                         input logic [N-1:0] h);
        req = r; en = e; hi = h;
    endtask

    initial begin
        m_served = '0; m_hptr = 0; m_lptr = 0; m_exp = '0;
        drive(4'hF, 4'hF, 4'h3);
        repeat (3) @(negedge clk);
        // R1: grant stays zero while reset is held.
        n_vec++;
        if (grant !== '0) begin
            n_miss++;
            $display("FAIL R1: grant=%b expected=%b during reset", grant, 4'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: ready but disabled channels are never granted.
        drive(4'hF, 4'h0, 4'h3);
        cycle("R2");
        cycle("R2");

        // R8: round-robin over four low-priority channels, including the wrap.
        drive(4'hF, 4'hF, 4'h0);
        for (int i = 0; i < 6; i++) cycle("R8");

        // R4/R5: two high, two low: hi,hi,lo,hi,hi,lo.
        drive(4'hF, 4'hF, 4'h3);
        for (int i = 0; i < 8; i++) cycle("R4");
        for (int i = 0; i < 3; i++) cycle("R5");

        // R6: only low-priority channels ready; taken without waiting.
        drive(4'hC, 4'hF, 4'h3);
        cycle("R6");
        cycle("R6");

        // R7 and R3: only high-priority channels ready; no idle slot.
        drive(4'h3, 4'hF, 4'h3);
        for (int i = 0; i < 5; i++) cycle("R7");
        drive(4'h1, 4'hF, 4'h1);
        cycle("R3");
        cycle("R3");

        // R9: disable channel 1 mid-stream, then enable it again.
        drive(4'hF, 4'hF, 4'h0);
        cycle("R9");
        drive(4'hF, 4'hD, 4'h0);
        for (int i = 0; i < 4; i++) cycle("R9");
        drive(4'hF, 4'hF, 4'h0);
        for (int i = 0; i < 4; i++) cycle("R9");

        // Sweep over all input combinations; the state carries across them.
        for (int v = 0; v < 4096; v++) begin
            drive(v[3:0], v[7:4], v[11:8]);
            for (int j = 0; j < 3; j++) cycle("R8 sweep");
        end

        // R1: reset again mid-run clears the grant.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        n_vec++;
        if (grant !== '0) begin
            n_miss++;
            $display("FAIL R1: grant=%b expected=%b after reset", grant, 4'b0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    // Watchdog: ends a hung run and counts it as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: cycles=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule